// File: doc/BRIEF.md
# CAN Transmit Request Tracker

This block keeps the command and status bookkeeping for a small set of transmit buffers (three by default) in a CAN controller. A register-write port carries three per-buffer command vectors: transmit request, self-reception request and abort. The block holds each buffer's request until a bit-level protocol engine takes it. It offers the engine one buffer at a time, and then waits for that buffer's outcome pulse.

Each buffer is in one of three states: free, pending (queued but not yet on the bus) or busy (the engine has started the frame). A request cannot be withdrawn by writing zero. Only the abort command removes it, and only while the buffer is still pending. A frame that has started always runs to an outcome reported by the engine. The block combines the state of all buffers into two flags. The first says that every buffer is free. The second says that every requested transmission succeeded. It also raises a sticky transmit interrupt and, for a successful self-reception request, a one-cycle receive indication.

Top module: `can_txreq_tracker`

## Requirements
- R1: A synchronous active-high reset leaves buf_free=1, tx_complete=1, tx_irq=0, rx_loop=0, and every buffer free so that tx_start_valid=0.
- R2: A cycle with cmd_valid=1 and bit i set in cmd_tx_req or cmd_self_req moves a free buffer i to pending. From the next cycle, buf_free=0 and tx_complete=0.
- R3: A pending buffer stays pending whenever neither an abort for it nor its start is seen. Writing 0 to its request bits has no effect.
- R4: A request write to a buffer that is pending or busy is ignored. It does not restart the buffer and does not change the buffer's self-reception flag.
- R5: tx_start_valid=1 exactly when no buffer is busy and at least one is pending. tx_start_idx is then the lowest pending index. eng_started[i] moves buffer i to busy only when buffer i is the one offered, and at most one buffer is busy at any time.
- R6: cmd_valid=1 with cmd_abort bit i set returns a pending buffer i to free, and that buffer does not count as a success.
- R7: An abort command for a busy buffer is ignored. The buffer stays busy until eng_done or eng_lost arrives for it. eng_done takes priority if both arrive in the same cycle.
- R8: buf_free is 1 exactly when no buffer is pending or busy. It is registered and follows the buffer states with no extra delay.
- R9: tx_complete is 1 exactly when every buffer's most recent request ended with eng_done. A request that was aborted (by command or by eng_lost) holds it at 0 until that buffer is requested again and succeeds.
- R10: tx_irq is set in the cycle after any buffer becomes free after being pending or busy. It stays set until irq_ack=1 is seen, and a new setting event wins over a simultaneous irq_ack.
- R11: tx_start_self shows whether the offered buffer carries a self-reception request. When such a buffer ends with eng_done, rx_loop is 1 for exactly one cycle, together with tx_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_tx_req | input | NUM_BUF | Per-buffer transmit request |
| cmd_self_req | input | NUM_BUF | Per-buffer self-reception request |
| cmd_abort | input | NUM_BUF | Per-buffer abort |
| irq_ack | input | 1 | Clears the transmit interrupt |
| eng_started | input | NUM_BUF | Engine took the offered buffer onto the bus |
| eng_done | input | NUM_BUF | Busy buffer finished successfully |
| eng_lost | input | NUM_BUF | Busy buffer ended without success |
| tx_start_valid | output | 1 | A buffer is offered to the engine |
| tx_start_idx | output | IDX_W | Index of the offered buffer |
| tx_start_self | output | 1 | Offered buffer is a self-reception request |
| buf_free | output | 1 | All buffers free |
| tx_complete | output | 1 | All requested transmissions succeeded |
| tx_irq | output | 1 | Sticky transmit interrupt |
| rx_loop | output | 1 | One-cycle receive indication for a successful self-reception request |

## Verification
Directed sequences come first. They check the priority order with two buffers queued at once and a write of zeros to a pending buffer. They also send an abort and a repeated request to a busy buffer, a start pulse for a buffer that is not offered, and then compare a command abort with a successful completion. Together these separate withdrawal by writing zero from withdrawal by abort, and a restarted buffer from an ignored write. Seeded random traffic follows. It mixes overlapping commands, engine pulses aimed at the wrong buffer, and same-cycle outcome, abort and acknowledge collisions. A bench model of the requirements checks every output on every cycle, which shows up any ordering or priority mistake.

// File: rtl/can_txreq_pkg.sv
package can_txreq_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_PEND = 2'd1,
    SLOT_BUSY = 2'd2
  } slot_state_e;
endpackage

// File: rtl/can_txreq_slot.sv
module can_txreq_slot
  import can_txreq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_req,
  input  logic        wr_self,
  input  logic        wr_abort,
  input  logic        grant,
  input  logic        eng_done,
  input  logic        eng_lost,
  output slot_state_e st_q,
  output slot_state_e st_d,
  output logic        ok_q,
  output logic        ok_d,
  output logic        self_q,
  output logic        fin_any,
  output logic        fin_ok
);
  logic self_d;

  always_comb begin
    st_d    = st_q;
    ok_d    = ok_q;
    self_d  = self_q;
    fin_any = 1'b0;
    fin_ok  = 1'b0;
    case (st_q)
      SLOT_IDLE: if (wr_req) begin
        st_d   = SLOT_PEND;
        ok_d   = 1'b0;
        self_d = wr_self;
      end
      SLOT_PEND: begin
        if (grant) begin
          st_d = SLOT_BUSY;
        end else if (wr_abort) begin
          st_d    = SLOT_IDLE;
          fin_any = 1'b1;
        end
      end
      SLOT_BUSY: begin
        if (eng_done) begin
          st_d    = SLOT_IDLE;
          ok_d    = 1'b1;
          fin_any = 1'b1;
          fin_ok  = 1'b1;
        end else if (eng_lost) begin
          st_d    = SLOT_IDLE;
          fin_any = 1'b1;
        end
      end
      default: st_d = SLOT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SLOT_IDLE;
      ok_q   <= 1'b1;
      self_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ok_q   <= ok_d;
      self_q <= self_d;
    end
  end

  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst)
    (st_q == SLOT_PEND && !grant && !wr_abort) |=> (st_q == SLOT_PEND)); // R3
  AST_BUSY_UNTIL_END: assert property (@(posedge clk) disable iff (rst)
    (st_q == SLOT_BUSY && !eng_done && !eng_lost) |=> (st_q == SLOT_BUSY)); // R7
  AST_ABORT_NOT_OK: assert property (@(posedge clk) disable iff (rst)
    (st_q == SLOT_PEND && wr_abort && !grant) |=> !ok_q); // R6
  AST_SELF_KEPT: assert property (@(posedge clk) disable iff (rst)
    (st_q != SLOT_IDLE) |=> $stable(self_q)); // R4
endmodule

// File: rtl/can_txreq_arb.sv
module can_txreq_arb #(
  parameter int NUM_BUF = 3,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_BUF-1:0] pend,
  input  logic [NUM_BUF-1:0] busy,
  output logic               offer_valid,
  output logic [IDX_W-1:0]   offer_idx
);
  always_comb begin
    offer_idx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (pend[i]) offer_idx = IDX_W'(i);
    end
    offer_valid = (|pend) && !(|busy);
  end
endmodule

// File: rtl/can_txreq_status.sv
module can_txreq_status #(
  parameter int NUM_BUF = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] idle_d,
  input  logic [NUM_BUF-1:0] ok_d,
  input  logic [NUM_BUF-1:0] fin_any,
  input  logic [NUM_BUF-1:0] fin_loop,
  input  logic               irq_ack,
  output logic               buf_free,
  output logic               tx_complete,
  output logic               tx_irq,
  output logic               rx_loop
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_free    <= 1'b1;
      tx_complete <= 1'b1;
      tx_irq      <= 1'b0;
      rx_loop     <= 1'b0;
    end else begin
      buf_free    <= &idle_d;
      tx_complete <= &ok_d;
      tx_irq      <= (|fin_any) || (tx_irq && !irq_ack);
      rx_loop     <= |fin_loop;
    end
  end

  AST_RESET_FLAGS: assert property (@(posedge clk)
    rst |=> (buf_free && tx_complete && !tx_irq && !rx_loop)); // R1
  AST_COMPLETE_IMPLIES_FREE: assert property (@(posedge clk) disable iff (rst)
    tx_complete |-> buf_free); // R9
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (tx_irq && !irq_ack) |=> tx_irq); // R10
  AST_LOOP_WITH_IRQ: assert property (@(posedge clk) disable iff (rst)
    rx_loop |-> tx_irq); // R11
endmodule

// File: rtl/can_txreq_tracker.sv
module can_txreq_tracker
  import can_txreq_pkg::*;
#(
  parameter int NUM_BUF = 3,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [NUM_BUF-1:0] cmd_tx_req,
  input  logic [NUM_BUF-1:0] cmd_self_req,
  input  logic [NUM_BUF-1:0] cmd_abort,
  input  logic               irq_ack,
  input  logic [NUM_BUF-1:0] eng_started,
  input  logic [NUM_BUF-1:0] eng_done,
  input  logic [NUM_BUF-1:0] eng_lost,
  output logic               tx_start_valid,
  output logic [IDX_W-1:0]   tx_start_idx,
  output logic               tx_start_self,
  output logic               buf_free,
  output logic               tx_complete,
  output logic               tx_irq,
  output logic               rx_loop
);
  logic [NUM_BUF-1:0] pend, busy, idle_d, ok_d, self_q, fin_any, fin_loop;
  logic               offer_valid;
  logic [IDX_W-1:0]   offer_idx;

  can_txreq_arb #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_arb (
    .pend        (pend),
    .busy        (busy),
    .offer_valid (offer_valid),
    .offer_idx   (offer_idx)
  );

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
    slot_state_e st_q, st_d;
    logic        ok_q, ok_dd, fin_ok, grant;

    assign grant = eng_started[g] && offer_valid && (offer_idx == IDX_W'(g));

    can_txreq_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_req   (cmd_valid && (cmd_tx_req[g] || cmd_self_req[g])),
      .wr_self  (cmd_self_req[g]),
      .wr_abort (cmd_valid && cmd_abort[g]),
      .grant    (grant),
      .eng_done (eng_done[g]),
      .eng_lost (eng_lost[g]),
      .st_q     (st_q),
      .st_d     (st_d),
      .ok_q     (ok_q),
      .ok_d     (ok_dd),
      .self_q   (self_q[g]),
      .fin_any  (fin_any[g]),
      .fin_ok   (fin_ok)
    );

    assign pend[g]     = (st_q == SLOT_PEND);
    assign busy[g]     = (st_q == SLOT_BUSY);
    assign idle_d[g]   = (st_d == SLOT_IDLE);
    assign ok_d[g]     = ok_dd;
    assign fin_loop[g] = fin_ok && self_q[g];

    AST_OK_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
      ok_q |-> (st_q == SLOT_IDLE)); // R9
  end

  can_txreq_status #(.NUM_BUF(NUM_BUF)) u_status (
    .clk         (clk),
    .rst         (rst),
    .idle_d      (idle_d),
    .ok_d        (ok_d),
    .fin_any     (fin_any),
    .fin_loop    (fin_loop),
    .irq_ack     (irq_ack),
    .buf_free    (buf_free),
    .tx_complete (tx_complete),
    .tx_irq      (tx_irq),
    .rx_loop     (rx_loop)
  );

  assign tx_start_valid = offer_valid;
  assign tx_start_idx   = offer_idx;
  assign tx_start_self  = self_q[offer_idx];

  AST_SINGLE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $countones(busy) <= 1); // R5
  AST_OFFER_PENDING: assert property (@(posedge clk) disable iff (rst)
    tx_start_valid |-> pend[tx_start_idx]); // R5
  AST_FREE_MEANS_NO_OFFER: assert property (@(posedge clk) disable iff (rst)
    buf_free |-> !tx_start_valid); // R8
endmodule

// File: tb/can_txreq_tracker_tb.sv
module can_txreq_tracker_tb;
  localparam int N  = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [N-1:0]  cmd_tx_req = '0, cmd_self_req = '0, cmd_abort = '0;
  logic          irq_ack = 1'b0;
  logic [N-1:0]  eng_started = '0, eng_done = '0, eng_lost = '0;
  logic          tx_start_valid, tx_start_self, buf_free, tx_complete, tx_irq, rx_loop;
  logic [IW-1:0] tx_start_idx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model: 0 free, 1 pending, 2 busy
  int m_st[N];
  bit m_ok[N];
  bit m_self[N];
  bit m_irq, m_rx;

  always #2.5 clk = ~clk;

  can_txreq_tracker #(.NUM_BUF(N)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_tx_req(cmd_tx_req),
    .cmd_self_req(cmd_self_req), .cmd_abort(cmd_abort), .irq_ack(irq_ack),
    .eng_started(eng_started), .eng_done(eng_done), .eng_lost(eng_lost),
    .tx_start_valid(tx_start_valid), .tx_start_idx(tx_start_idx),
    .tx_start_self(tx_start_self), .buf_free(buf_free),
    .tx_complete(tx_complete), .tx_irq(tx_irq), .rx_loop(rx_loop)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  function automatic bit exp_valid();
    bit anyp = 0, anyb = 0;
    for (int i = 0; i < N; i++) begin
      if (m_st[i] == 1) anyp = 1;
      if (m_st[i] == 2) anyb = 1;
    end
    return anyp && !anyb;
  endfunction

  function automatic int exp_idx();
    for (int i = 0; i < N; i++) if (m_st[i] == 1) return i;
    return 0;
  endfunction

  function automatic bit exp_free();
    for (int i = 0; i < N; i++) if (m_st[i] != 0) return 0;
    return 1;
  endfunction

  function automatic bit exp_complete();
    for (int i = 0; i < N; i++) if (!m_ok[i]) return 0;
    return 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_st[i] = 0; m_ok[i] = 1; m_self[i] = 0;
    end
    m_irq = 0; m_rx = 0;
  endtask

  task automatic check_all();
    bit v = exp_valid();
    chk("R5 tx_start_valid", tx_start_valid, v);
    if (v) begin
      chk("R5 tx_start_idx", tx_start_idx, exp_idx());
      chk("R11 tx_start_self", tx_start_self, m_self[exp_idx()]);
    end
    chk("R8 buf_free", buf_free, exp_free());
    chk("R9 tx_complete", tx_complete, exp_complete());
    chk("R10 tx_irq", tx_irq, m_irq);
    chk("R11 rx_loop", rx_loop, m_rx);
  endtask

  // drive one cycle at a falling edge, advance the model, check at next falling edge
  task automatic cyc(input bit cv, input bit [N-1:0] rq, input bit [N-1:0] sf,
                     input bit [N-1:0] ab, input bit [N-1:0] stt,
                     input bit [N-1:0] dn, input bit [N-1:0] ls, input bit ack);
    bit v = exp_valid();
    int ix = exp_idx();
    bit fin = 0, loop = 0;
    cmd_valid = cv; cmd_tx_req = rq; cmd_self_req = sf; cmd_abort = ab;
    eng_started = stt; eng_done = dn; eng_lost = ls; irq_ack = ack;
    for (int i = 0; i < N; i++) begin
      case (m_st[i])
        0: if (cv && (rq[i] || sf[i])) begin
             m_st[i] = 1; m_ok[i] = 0; m_self[i] = sf[i];
           end
        1: if (stt[i] && v && ix == i) m_st[i] = 2;
           else if (cv && ab[i]) begin m_st[i] = 0; fin = 1; end
        default: if (dn[i]) begin
                   m_st[i] = 0; m_ok[i] = 1; fin = 1;
                   if (m_self[i]) loop = 1;
                 end else if (ls[i]) begin m_st[i] = 0; fin = 1; end
      endcase
    end
    m_irq = fin || (m_irq && !ack);
    m_rx  = loop;
    @(negedge clk);
    cycles++;
    check_all();
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 buf_free", buf_free, 1);
    chk("R1 tx_complete", tx_complete, 1);
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 tx_start_valid", tx_start_valid, 0);
    chk("R1 rx_loop", rx_loop, 0);

    // R2 R5 R11: queue buf2 plain and buf1 self; lowest index offered
    cyc(1, 3'b100, 3'b010, 0, 0, 0, 0, 0);
    chk("R2 buf_free", buf_free, 0);
    chk("R2 tx_complete", tx_complete, 0);
    chk("R5 lowest idx", tx_start_idx, 1);
    chk("R11 offer self", tx_start_self, 1);

    // R3: writing zero does not withdraw
    cyc(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 still offered", tx_start_valid, 1);

    // R5: start for buffer 2 (not offered) ignored
    cyc(0, 0, 0, 0, 3'b100, 0, 0, 0);
    chk("R5 wrong start ignored", tx_start_idx, 1);

    // buf1 starts
    cyc(0, 0, 0, 0, 3'b010, 0, 0, 0);
    chk("R5 busy blocks offer", tx_start_valid, 0);

    // R7 abort busy buf1 ignored; R4 rewrite busy buf1 ignored
    cyc(1, 3'b010, 0, 3'b010, 0, 0, 0, 0);
    chk("R7 abort busy ignored", tx_start_valid, 0);
    chk("R7 abort busy no irq", tx_irq, 0);

    // buf1 done: receive indication and irq, buf2 offered next
    cyc(0, 0, 0, 0, 0, 3'b010, 0, 0);
    chk("R11 rx_loop pulse", rx_loop, 1);
    chk("R10 irq on done", tx_irq, 1);
    chk("R4 no restart", tx_start_idx, 2);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R11 rx_loop one cycle", rx_loop, 0);
    chk("R10 irq held", tx_irq, 1);

    // R6 abort pending buf2 together with ack: set wins
    cyc(1, 0, 0, 3'b100, 0, 0, 0, 1);
    chk("R6 free after abort", buf_free, 1);
    chk("R9 abort not complete", tx_complete, 0);
    chk("R10 set beats ack", tx_irq, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R10 ack clears", tx_irq, 0);

    // R9: re-request buf2 and succeed restores complete
    cyc(1, 3'b100, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 3'b100, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 3'b100, 3'b100, 0);
    chk("R9 complete after success", tx_complete, 1);
    chk("R7 done priority", tx_irq, 1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit cv = ($urandom % 4) == 0;
      bit [N-1:0] rq = 0, sf = 0, ab = 0, stt = 0, dn = 0, ls = 0;
      bit ack = ($urandom % 4) == 0;
      for (int i = 0; i < N; i++) begin
        rq[i] = ($urandom % 3) == 0;
        sf[i] = ($urandom % 4) == 0;
        ab[i] = ($urandom % 5) == 0;
        if (m_st[i] == 2) begin
          dn[i] = ($urandom % 3) == 0;
          ls[i] = ($urandom % 8) == 0;
        end else begin
          dn[i] = ($urandom % 16) == 0;
          ls[i] = ($urandom % 16) == 0;
        end
      end
      if (exp_valid() && ($urandom % 2) == 0) stt[exp_idx()] = 1'b1;
      if (($urandom % 8) == 0) stt[$urandom % N] = 1'b1;
      cyc(cv, rq, sf, ab, stt, dn, ls, ack);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule